// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Spare-Bit Generator

This block sits in the transmit path of a 2.048 Mbit/s E1 stream and rewrites one bit per frame: the first bit of timeslot zero, the international spare-bit position. Every other bit of the serial stream passes through with one clock of latency. A frame-sync input is high across the eight bits of timeslot zero. A sync-frame flag tells the block whether the current frame carries the alignment word or not.

With the CRC enable low, the block fills the spare bit from one of two user inputs, picked by the sync-frame flag. With the enable high, it runs a 16-frame multiframe made of two 8-frame halves. It computes a 4-bit CRC over every outgoing bit of each half and sends that CRC, most significant bit first, in the sync frames of the following half. The non-sync frames carry a 6-bit multiframe alignment word followed by the two user bits.

A 3-bit pair counter gives the frame's position in the multiframe. A sync frame uses the current count. A non-sync frame also uses it and then advances it.

Top module: `e1_spare_gen`

## Requirements
- R1: While rst_n is low, data_o is 0. The pair counter returns to 0 and the CRC shift register is cleared.
- R2: With crc_en_i low, the spare bit equals usr_s_i if sync_i is high at the frame start, and usr_n_i otherwise.
- R3: A frame start is a cycle where fs_i is high and was low in the previous cycle. Only the bit presented in that cycle is the spare bit. The later cycles of the fs_i pulse are ordinary data.
- R4: The CRC uses the generator x^4 + x + 1 and is the remainder of the message times x^4. The message is every outgoing bit of a sub-multiframe, in transmit order, with the sync-frame spare bits taken as 0. A sub-multiframe begins at a sync-frame start where the pair count is 0 or 4. The shift register is cleared there.
- R5: With crc_en_i high, a sync frame whose pair count is k carries bit (3 - k mod 4) of the CRC word of the previous sub-multiframe. Bit 3 is the first bit sent.
- R6: With crc_en_i high, non-sync frames with pair counts 0 to 5 carry the alignment bits 0,0,1,0,1,1 in that order.
- R7: With crc_en_i high, the non-sync frame with pair count 6 carries usr_s_i, and the one with pair count 7 carries usr_n_i.
- R8: The pair count advances by one after every non-sync frame start, wraps from 7 to 0, and does not change otherwise.
- R9: Every bit that is not a spare bit appears on data_o unchanged, one clock after it was on data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | High during the eight bits of timeslot zero |
| sync_i | input | 1 | High in frames that carry the alignment word |
| crc_en_i | input | 1 | 1 selects CRC multiframe mode, 0 selects plain mode |
| data_i | input | 1 | Serial data in |
| usr_s_i | input | 1 | User bit for sync frames |
| usr_n_i | input | 1 | User bit for non-sync frames |
| data_o | output | 1 | Serial data out with the spare bit substituted |

## Verification
The bound checker tests four things on every cycle: the one-cycle pass-through of non-spare bits, the plain-mode choice between the user bits, the alignment-word and user-bit slots of non-sync frames, and the stepping of the pair counter. The CRC content cannot be checked by a single-cycle property, because it depends on 2048 earlier bits. It is shown only by the bench's reference model, which does polynomial long division over a queue of each sub-multiframe's bits. The model runs over random, all-zero, all-one and alternating data, and over mode changes between frames.

// File: rtl/e1sp_pkg.sv
package e1sp_pkg;
    localparam int CRC_W    = 4;
    localparam int PAIR_W   = 3;
    localparam int MFAS_W   = (2 ** PAIR_W) - 2;
    localparam logic [CRC_W-1:0]  CRC_POLY = 4'b0011;
    localparam logic [MFAS_W-1:0] MFAS_PAT = 6'b001011;

    typedef struct packed {
        logic              fs_prev;
        logic [PAIR_W-1:0] pair;
    } trk_state_t;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] hold;
    } crc_state_t;

    typedef struct packed {
        logic dout;
    } out_state_t;
endpackage

// File: rtl/e1sp_frame_trk.sv
module e1sp_frame_trk
    import e1sp_pkg::*;
#(
    parameter int P_W = PAIR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fs_i,
    input  logic           sync_i,
    output logic           start_o,
    output logic           smf_start_o,
    output logic [P_W-1:0] pair_o
);
    localparam int SUB_W = P_W - 1;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.fs_prev = fs_i;
        start_o      = fs_i & ~st_q.fs_prev;
        smf_start_o  = start_o & sync_i & (st_q.pair[SUB_W-1:0] == '0);
        if (start_o && !sync_i) begin
            st_d.pair = st_q.pair + 1'b1;
        end
        pair_o = st_q.pair;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/e1sp_crc_eng.sv
module e1sp_crc_eng
    import e1sp_pkg::*;
#(
    parameter int               W    = CRC_W,
    parameter logic [W-1:0]     POLY = CRC_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smf_start_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    crc_state_t st_d, st_q;
    logic [W-1:0] base;
    logic         fb;

    always_comb begin
        st_d = st_q;
        base = smf_start_i ? '0 : st_q.crc;
        fb   = bit_i ^ base[W-1];
        st_d.crc = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        if (smf_start_i) begin
            st_d.hold = st_q.crc;
        end
        word_o = smf_start_i ? st_q.crc : st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/e1sp_spare_sel.sv
module e1sp_spare_sel
    import e1sp_pkg::*;
#(
    parameter int P_W = PAIR_W,
    parameter int W   = CRC_W
) (
    input  logic           crc_en_i,
    input  logic           sync_i,
    input  logic [P_W-1:0] pair_i,
    input  logic [W-1:0]   word_i,
    input  logic           usr_s_i,
    input  logic           usr_n_i,
    output logic           spare_o
);
    localparam int SUB_W = P_W - 1;
    localparam int MF_W  = (2 ** P_W) - 2;

    logic [SUB_W-1:0] crc_idx;
    logic [P_W-1:0]   mf_idx;

    always_comb begin
        crc_idx = SUB_W'(W - 1) - pair_i[SUB_W-1:0];
        mf_idx  = P_W'(MF_W - 1) - pair_i;
        if (!crc_en_i) begin
            spare_o = sync_i ? usr_s_i : usr_n_i;
        end else if (sync_i) begin
            spare_o = word_i[crc_idx];
        end else if (pair_i < P_W'(MF_W)) begin
            spare_o = MFAS_PAT[mf_idx];
        end else if (pair_i == P_W'(MF_W)) begin
            spare_o = usr_s_i;
        end else begin
            spare_o = usr_n_i;
        end
    end
endmodule

// File: rtl/e1_spare_gen.sv
module e1_spare_gen
    import e1sp_pkg::*;
#(
    parameter int P_W = PAIR_W,
    parameter int W   = CRC_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_i,
    input  logic sync_i,
    input  logic crc_en_i,
    input  logic data_i,
    input  logic usr_s_i,
    input  logic usr_n_i,
    output logic data_o
);
    logic           frame_start;
    logic           smf_start;
    logic [P_W-1:0] pair_cnt;
    logic [W-1:0]   crc_word;
    logic           spare_bit;
    logic           crc_bit;
    out_state_t     out_d, out_q;

    e1sp_frame_trk #(.P_W(P_W)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_i        (fs_i),
        .sync_i      (sync_i),
        .start_o     (frame_start),
        .smf_start_o (smf_start),
        .pair_o      (pair_cnt)
    );

    e1sp_crc_eng #(.W(W), .POLY(CRC_POLY)) u_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .smf_start_i (smf_start),
        .bit_i       (crc_bit),
        .word_o      (crc_word)
    );

    e1sp_spare_sel #(.P_W(P_W), .W(W)) u_sel (
        .crc_en_i (crc_en_i),
        .sync_i   (sync_i),
        .pair_i   (pair_cnt),
        .word_i   (crc_word),
        .usr_s_i  (usr_s_i),
        .usr_n_i  (usr_n_i),
        .spare_o  (spare_bit)
    );

    always_comb begin
        out_d.dout = frame_start ? spare_bit : data_i;
        crc_bit    = (frame_start && sync_i) ? 1'b0 : out_d.dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_o = out_q.dout;
endmodule

// File: rtl/e1_spare_gen_chk.sv
module e1_spare_gen_chk
    import e1sp_pkg::*;
#(
    parameter int P_W = PAIR_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sync_i,
    input logic           crc_en_i,
    input logic           data_i,
    input logic           usr_s_i,
    input logic           usr_n_i,
    input logic           data_o,
    input logic           frame_start,
    input logic [P_W-1:0] pair_cnt
);
    localparam int MF_W = (2 ** P_W) - 2;

    logic [P_W-1:0] mf_sel;
    logic           mf_bit;
    always_comb begin
        mf_sel = P_W'(MF_W - 1) - pair_cnt;
        mf_bit = MFAS_PAT[mf_sel];
    end

    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> data_o == $past(data_i));

    p_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !crc_en_i) |=>
            data_o == $past(sync_i ? usr_s_i : usr_n_i));

    p_mfas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && crc_en_i && !sync_i && pair_cnt < P_W'(MF_W)) |=>
            data_o == $past(mf_bit));

    p_user_s_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && crc_en_i && !sync_i && pair_cnt == P_W'(MF_W)) |=>
            data_o == $past(usr_s_i));

    p_user_n_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && crc_en_i && !sync_i && pair_cnt == P_W'(MF_W + 1)) |=>
            data_o == $past(usr_n_i));

    p_pair_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !sync_i) |=> pair_cnt == $past(pair_cnt) + 1'b1);

    p_pair_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && !sync_i) |=> $stable(pair_cnt));
endmodule

bind e1_spare_gen e1_spare_gen_chk #(.P_W(P_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_i),
    .crc_en_i    (crc_en_i),
    .data_i      (data_i),
    .usr_s_i     (usr_s_i),
    .usr_n_i     (usr_n_i),
    .data_o      (data_o),
    .frame_start (frame_start),
    .pair_cnt    (pair_cnt)
);

// File: tb/e1_spare_gen_tb.sv
`timescale 1ns/1ps
module e1_spare_gen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs = 1'b0, sync = 1'b0, crc_en = 1'b0, din = 1'b0;
    logic usr_s = 1'b0, usr_n = 1'b0;
    logic data_o;

    int n_cmp = 0, n_bad = 0;
    int n_r2 = 0, n_r5 = 0, n_r6 = 0, n_r7 = 0, n_r9 = 0;
    bit done = 1'b0;
    bit chk_on = 1'b0;

    always #10 clk = ~clk;

    e1_spare_gen u_dut (
        .clk(clk), .rst_n(rst_n), .fs_i(fs), .sync_i(sync),
        .crc_en_i(crc_en), .data_i(din), .usr_s_i(usr_s),
        .usr_n_i(usr_n), .data_o(data_o)
    );

    // Reference model: behavioural, bit queue plus long division
    bit    m_fs_prev;
    int    m_k;
    int    m_hold;
    bit    smf_q[$];
    bit    exp_bit;
    string exp_tag;

    function automatic int crc_of(ref bit q[$]);
        int r = 0;
        foreach (q[i]) begin
            r = (r << 1) | int'(q[i]);
            if (r & 16) r = r ^ 5'b10011;
        end
        for (int z = 0; z < 4; z++) begin
            r = r << 1;
            if (r & 16) r = r ^ 5'b10011;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fs_prev = 1'b0;
            m_k       = 0;
            m_hold    = 0;
            smf_q.delete();
            exp_bit   = 1'b0;
            exp_tag   = "R1";
        end else begin
            bit st;
            st = fs && !m_fs_prev;
            m_fs_prev = fs;
            if (st) begin
                if (sync && (m_k % 4 == 0)) begin
                    m_hold = crc_of(smf_q);
                    smf_q.delete();
                end
                if (!crc_en) begin
                    exp_bit = sync ? usr_s : usr_n;
                    exp_tag = "R2";
                end else if (sync) begin
                    exp_bit = m_hold[3 - (m_k % 4)];
                    exp_tag = "R4 R5";
                end else if (m_k < 6) begin
                    bit [5:0] pat = 6'b001011;
                    exp_bit = pat[5 - m_k];
                    exp_tag = "R6 R8";
                end else begin
                    exp_bit = (m_k == 6) ? usr_s : usr_n;
                    exp_tag = "R7 R8";
                end
            end else begin
                exp_bit = din;
                exp_tag = "R9 R3";
            end
            smf_q.push_back((st && sync) ? 1'b0 : exp_bit);
            if (st && !sync) m_k = (m_k + 1) % 8;
        end
    end

    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            n_cmp++;
            case (exp_tag)
                "R2":    n_r2++;
                "R4 R5": n_r5++;
                "R6 R8": n_r6++;
                "R7 R8": n_r7++;
                default: n_r9++;
            endcase
            if (data_o !== exp_bit) begin
                n_bad++;
                $display("FAIL %s: data_o=%0b expected=%0b at %0t",
                         exp_tag, data_o, exp_bit, $time);
            end
        end
    end

    task automatic check(input string tag, input bit got, input bit want);
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got=%0b expected=%0b", tag, got, want);
        end
    endtask

    task automatic check_cnt(input string tag, input int cnt);
        n_cmp++;
        if (cnt == 0) begin
            n_bad++;
            $display("FAIL %s: slot count=0 expected>0", tag);
        end
    endtask

    // mode: 0 random, 1 zeros, 2 ones, 3 alternating
    task automatic run_frame(input bit s, input bit en, input int mode);
        for (int b = 0; b < 256; b++) begin
            @(negedge clk);
            fs     = (b < 8);
            sync   = s;
            crc_en = en;
            if (b == 0) begin
                usr_s = 1'($urandom);
                usr_n = 1'($urandom);
            end
            case (mode)
                1:       din = 1'b0;
                2:       din = 1'b1;
                3:       din = 1'(b);
                default: din = 1'($urandom);
            endcase
        end
    endtask

    task automatic run_frames(input int n, input bit en, input int mode);
        for (int f = 0; f < n; f++) run_frame(1'((f % 2) == 0), en, mode);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                check("R1 reset output", data_o, 1'b0);
                din = 1'b1;
                @(negedge clk);
                check("R1 reset output held", data_o, 1'b0);
                rst_n = 1'b1;
                chk_on = 1'b1;
                run_frames(4, 1'b0, 0);
                run_frames(32, 1'b1, 0);
                run_frames(16, 1'b1, 1);
                run_frames(16, 1'b1, 2);
                run_frames(16, 1'b1, 3);
                run_frames(16, 1'b1, 0);
                run_frames(4, 1'b0, 3);
                @(negedge clk);
                check_cnt("R2", n_r2);
                check_cnt("R4 R5", n_r5);
                check_cnt("R6 R8", n_r6);
                check_cnt("R7 R8", n_r7);
                check_cnt("R9 R3", n_r9);
                done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
            end
        join_any
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: done=0 expected=1");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule